// File: doc/BRIEF.md
# Audio Preamplifier Control Register Receiver

This block is the serial configuration port of a stereo audio preamplifier. It is a receive-only I2C target: it answers a single fixed device address, takes a register pointer byte, then stores any number of data bytes into an eight-slot control map. The pointer advances by one after every data byte. It wraps from slot 7 to slot 0. Each new pointer byte reloads it. A STOP or a repeated START closes the transfer.

The stored values leave the block as decoded control fields. These are a common volume code with its zero-cross mute mode bit, separate right and left output attenuation codes, bass and treble codes, a general mute flag and a source-select code. A one-cycle strobe marks every write to the switch slot, so that a downstream mute timer can restart. SCL and SDA are asynchronous to the system clock. Both pass through synchronisers before any edge is interpreted. Acknowledge is an open-drain pull-down enable.

Top module: `apreamp_ctl_i2c`

## Requirements
- R1: Only the address byte 0x50 is acknowledged (bits 7..1 = 0101000, bit 0 = 0 for a write). After any other address byte, no later byte of that transfer is acknowledged and no output changes.
- R2: The pointer byte selects a slot with its bits 2..0 only; bits 7..3 are ignored. Slots are 0 volume, 1 right attenuation, 2 left attenuation, 5 bass, 6 treble, 7 switch.
- R3: After each data byte the pointer moves to the next slot, and slot 7 is followed by slot 0.
- R4: In the volume slot, bit 7 drives `zc_mode` and bits 5..0 drive `vol_code`. Bit 6 of the byte has no effect.
- R5: The attenuation slots drive their 6-bit codes from bits 5..0, and bits 7..6 are ignored. The bass and treble slots drive their 5-bit codes from bits 4..0.
- R6: In the switch slot, bit 7 drives `gen_mute` and bits 2..0 drive `src_sel`. The source codes are 111 for stereo A, 110 for stereo B and 0xx for mono.
- R7: Data bytes written to slots 3 and 4 change no output.
- R8: While `rst_n` is low, `gen_mute` becomes 1, every other field becomes 0, `sda_oe` is 0 and the receiver goes idle. After reset, bits clocked without a START are not acknowledged and write nothing.
- R9: `sw_wr_stb` is high for exactly one clock for each byte written to slot 7, in the same clock in which the switch fields take the new value. Switch fields never change without the strobe.
- R10: A STOP or a repeated START ends the transfer. A partially received byte is discarded. The first byte after a repeated START is an address byte.
- R11: The block pulls SDA low only during the ninth SCL period of an acknowledged byte. The pull-down starts and ends while SCL is low.
- R12: A data byte's fields change on the fourth rising clock edge after SCL of its eighth bit rises at the pin, and at most one slot's fields change per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| scl_i | input | 1 | Serial clock from the bus, asynchronous |
| sda_i | input | 1 | Serial data as seen on the bus, asynchronous |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| vol_code | output | 6 | Common volume code |
| zc_mode | output | 1 | Zero-cross mute mode select |
| att_r | output | 6 | Right output attenuation code |
| att_l | output | 6 | Left output attenuation code |
| bass_code | output | 5 | Bass control code |
| treb_code | output | 5 | Treble control code |
| gen_mute | output | 1 | General mute request |
| src_sel | output | 3 | Input source selection code |
| sw_wr_stb | output | 1 | One-cycle pulse per switch-slot write |

## Verification
The bench targets these corner cases:
- Pointer wrap from the switch slot to the volume slot. A design without the wrap would write past the map, or would write the volume slot while the strobe fires.
- Pointer bytes with high bits set. A design that decodes all eight bits would select no slot or the wrong one.
- A STOP or a repeated START in the middle of a byte. A design that commits partial bytes would corrupt bass or treble.
- Address bytes that differ in one bit, or that carry the read flag. A design with a loose compare would acknowledge them and accept writes.
- A reset in the middle of a transfer. A design that keeps receiver state would acknowledge bytes that follow without a START.
- Writes to the two unused slots. These must leave every field as it was.

// File: rtl/apreamp_pkg.sv
// Shared constants and types for the preamplifier control receiver.
// Assumes: one byte per register slot and an eight-slot map.
package apreamp_pkg;
    localparam int unsigned SLOT_W = 3;
    localparam int unsigned NSLOT  = 1 << SLOT_W;

    // Slot numbers; their order is visible to the bus master
    localparam logic [SLOT_W-1:0] SLOT_VOL   = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_ATT_R = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_ATT_L = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_BASS  = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_TREB  = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_SW    = 3'd7;

    // Receiver phase within one transfer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } rx_phase_t;
endpackage

// File: rtl/i2c_pin_sync.sv
// Brings SCL and SDA into the clk domain and reports edges and bus events.
// Assumes: the bus is idle-high; the reset value of every stage is 1.
module i2c_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;
    logic scl_now, scl_old, sda_now, sda_old;

    // Synchroniser chains plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    // Event decode: SDA moving while SCL stays high marks START or STOP
    always_comb begin
        scl_now  = scl_p[STAGES-1];
        scl_old  = scl_p[STAGES];
        sda_now  = sda_p[STAGES-1];
        sda_old  = sda_p[STAGES];
        scl_rise = scl_now & ~scl_old;
        scl_fall = ~scl_now & scl_old;
        sda_lvl  = sda_now;
        start_ev = scl_now & scl_old & sda_old & ~sda_now;
        stop_ev  = scl_now & scl_old & ~sda_old & sda_now;
    end
endmodule

// File: rtl/i2c_wr_rx.sv
// Write-only byte receiver: address match, pointer load, data byte issue,
// pointer auto-increment with wrap, acknowledge generation.
// Assumes: events arrive from i2c_pin_sync. Bit 6 of data bytes is not
// carried out, because no slot uses it.
module i2c_wr_rx
    import apreamp_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic              wr_stb,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [6:0]        wr_val,
    output logic              ack_oe
);
    rx_phase_t         phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        shreg;
    logic [SLOT_W-1:0] ptr;
    logic              ack_pend;
    logic              ack_drv;
    logic [7:0]        byte_in;
    logic              rx_active;

    // Byte currently completing and whether bits are being collected
    always_comb begin
        byte_in   = {shreg, sda_lvl};
        rx_active = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);
    end

    // Transfer sequencing, bit shifting, pointer handling and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            ack_pend <= 1'b0;
            ack_drv  <= 1'b0;
            wr_stb   <= 1'b0;
            wr_slot  <= '0;
            wr_val   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_ev) begin
                phase    <= PH_ADDR;
                bit_cnt  <= '0;
                ack_pend <= 1'b0;
                ack_drv  <= 1'b0;
            end else if (stop_ev) begin
                phase    <= PH_IDLE;
                bit_cnt  <= '0;
                ack_pend <= 1'b0;
                ack_drv  <= 1'b0;
            end else if (ack_drv) begin
                if (scl_fall) ack_drv <= 1'b0;
            end else if (ack_pend) begin
                if (scl_fall) begin
                    ack_pend <= 1'b0;
                    ack_drv  <= 1'b1;
                end
            end else if (scl_rise && rx_active) begin
                shreg   <= byte_in[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_ADDR: begin
                            if (byte_in == DEV_ADDR) begin
                                phase    <= PH_SUB;
                                ack_pend <= 1'b1;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_SUB: begin
                            ptr      <= byte_in[SLOT_W-1:0];
                            phase    <= PH_DATA;
                            ack_pend <= 1'b1;
                        end
                        default: begin
                            wr_stb   <= 1'b1;
                            wr_slot  <= ptr;
                            wr_val   <= {byte_in[7], byte_in[5:0]};
                            ptr      <= ptr + 1'b1;
                            ack_pend <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    assign ack_oe = ack_drv;
endmodule

// File: rtl/ctl_fields.sv
// Control field storage: one write per byte. Unused slots have no storage.
// Assumes: wr_val[6] carries byte bit 7 and wr_val[5:0] carry byte bits 5..0.
module ctl_fields
    import apreamp_pkg::*;
#(
    parameter int unsigned VOL_W  = 6,
    parameter int unsigned ATT_W  = 6,
    parameter int unsigned TONE_W = 5,
    parameter int unsigned SRC_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [6:0]                  wr_val,
    output logic [VOL_W-1:0]            vol_code,
    output logic                        zc_mode,
    output logic [1:0][ATT_W-1:0]       att_code,
    output logic [1:0][TONE_W-1:0]      tone_code,
    output logic                        gen_mute,
    output logic [SRC_W-1:0]            src_sel,
    output logic                        sw_stb
);
    localparam int unsigned NUSED = 6;

    // Slot number of each stored register, in field order
    function automatic logic [SLOT_W-1:0] used_slot(input int unsigned idx);
        case (idx)
            0:       return SLOT_VOL;
            1:       return SLOT_ATT_R;
            2:       return SLOT_ATT_L;
            3:       return SLOT_BASS;
            4:       return SLOT_TREB;
            default: return SLOT_SW;
        endcase
    endfunction

    logic [NUSED-1:0] hit;

    for (genvar g = 0; g < NUSED; g++) begin : g_hit
        assign hit[g] = wr_stb && (wr_slot == used_slot(g));
    end

    // Volume slot: mode bit and code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_code <= '0;
            zc_mode  <= 1'b0;
        end else if (hit[0]) begin
            vol_code <= wr_val[VOL_W-1:0];
            zc_mode  <= wr_val[6];
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_att
        // One attenuation register per output channel
        always_ff @(posedge clk) begin
            if (!rst_n)          att_code[c] <= '0;
            else if (hit[1 + c]) att_code[c] <= wr_val[ATT_W-1:0];
        end
    end

    for (genvar t = 0; t < 2; t++) begin : g_tone
        // Bass (t=0) and treble (t=1) registers
        always_ff @(posedge clk) begin
            if (!rst_n)          tone_code[t] <= '0;
            else if (hit[3 + t]) tone_code[t] <= wr_val[TONE_W-1:0];
        end
    end

    // Switch slot: general mute (set by reset), source code, write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_mute <= 1'b1;
            src_sel  <= '0;
            sw_stb   <= 1'b0;
        end else begin
            sw_stb <= hit[5];
            if (hit[5]) begin
                gen_mute <= wr_val[6];
                src_sel  <= wr_val[SRC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/apreamp_ctl_i2c.sv
// Top of the preamplifier control receiver: pin synchroniser, byte receiver,
// field storage. Assumes: open-drain SDA pad driven low when sda_oe is high.
module apreamp_ctl_i2c
    import apreamp_pkg::*;
#(
    parameter logic [7:0]  DEV_ADDR    = 8'h50,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VOL_W       = 6,
    parameter int unsigned ATT_W       = 6,
    parameter int unsigned TONE_W      = 5,
    parameter int unsigned SRC_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [VOL_W-1:0]  vol_code,
    output logic              zc_mode,
    output logic [ATT_W-1:0]  att_r,
    output logic [ATT_W-1:0]  att_l,
    output logic [TONE_W-1:0] bass_code,
    output logic [TONE_W-1:0] treb_code,
    output logic              gen_mute,
    output logic [SRC_W-1:0]  src_sel,
    output logic              sw_wr_stb
);
    logic scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
    logic                   wr_stb;
    logic [SLOT_W-1:0]      wr_slot;
    logic [6:0]             wr_val;
    logic [1:0][ATT_W-1:0]  att_code;
    logic [1:0][TONE_W-1:0] tone_code;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_wr_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .wr_stb   (wr_stb),
        .wr_slot  (wr_slot),
        .wr_val   (wr_val),
        .ack_oe   (sda_oe)
    );

    ctl_fields #(
        .VOL_W  (VOL_W),
        .ATT_W  (ATT_W),
        .TONE_W (TONE_W),
        .SRC_W  (SRC_W)
    ) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_slot   (wr_slot),
        .wr_val    (wr_val),
        .vol_code  (vol_code),
        .zc_mode   (zc_mode),
        .att_code  (att_code),
        .tone_code (tone_code),
        .gen_mute  (gen_mute),
        .src_sel   (src_sel),
        .sw_stb    (sw_wr_stb)
    );

    // Channel and tone fields out to named ports
    always_comb begin
        att_r     = att_code[0];
        att_l     = att_code[1];
        bass_code = tone_code[0];
        treb_code = tone_code[1];
    end
endmodule

// File: rtl/apreamp_ctl_chk.sv
// Temporal checks on the receiver's ports, bound to every instance of the top.
module apreamp_ctl_chk #(
    parameter int unsigned VOL_W  = 6,
    parameter int unsigned ATT_W  = 6,
    parameter int unsigned TONE_W = 5,
    parameter int unsigned SRC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [VOL_W-1:0]  vol_code,
    input logic              zc_mode,
    input logic [ATT_W-1:0]  att_r,
    input logic [ATT_W-1:0]  att_l,
    input logic [TONE_W-1:0] bass_code,
    input logic [TONE_W-1:0] treb_code,
    input logic              gen_mute,
    input logic [SRC_W-1:0]  src_sel,
    input logic              sw_wr_stb
);
    // R8
    gmu_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (gen_mute && !sda_oe));

    // R11
    ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R11
    ack_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_i);

    // R9
    sw_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen_mute != $past(gen_mute)) || (src_sel != $past(src_sel))) |-> sw_wr_stb);

    // R9
    sw_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_stb |=> !sw_wr_stb);

    // R12
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({(vol_code != $past(vol_code)) || (zc_mode != $past(zc_mode)),
                    att_r != $past(att_r),
                    att_l != $past(att_l),
                    bass_code != $past(bass_code),
                    treb_code != $past(treb_code),
                    (gen_mute != $past(gen_mute)) || (src_sel != $past(src_sel))}) <= 1);
endmodule

bind apreamp_ctl_i2c apreamp_ctl_chk #(
    .VOL_W  (VOL_W),
    .ATT_W  (ATT_W),
    .TONE_W (TONE_W),
    .SRC_W  (SRC_W)
) u_chk (.*);

// File: tb/sim_apreamp_ctl_i2c.sv
// Bench: bus master tasks, behavioural slot model, per-clock comparison.
module sim_apreamp_ctl_i2c;
    localparam int HP = 8;
    localparam logic [7:0] DEV = 8'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, zc_mode, gen_mute, sw_wr_stb;
    logic [5:0] vol_code, att_r, att_l;
    logic [4:0] bass_code, treb_code;
    logic [2:0] src_sel;
    wire  sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    apreamp_ctl_i2c u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .vol_code(vol_code), .zc_mode(zc_mode), .att_r(att_r), .att_l(att_l),
        .bass_code(bass_code), .treb_code(treb_code), .gen_mute(gen_mute),
        .src_sel(src_sel), .sw_wr_stb(sw_wr_stb)
    );

    int vectors = 0, miscmp = 0, stb_seen = 0;
    int pend_cnt = 0, pend_slot = 0, rst_pend = 0;
    logic [7:0] pend_val = 8'h00;
    logic [7:0] mreg [0:7];
    logic [7:0] dq [$];
    bit cmp_on = 1'b0, done = 1'b0, exp_stb = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int k = 0; k < 8; k++) mreg[k] = 8'h00;
        mreg[7] = 8'h80;
    endfunction

    // Model timing and per-clock comparison of every output field
    always @(negedge clk) begin
        exp_stb = 1'b0;
        if (rst_pend > 0) begin
            rst_pend--;
            if (rst_pend == 0) model_reset();
        end
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                mreg[pend_slot] = pend_val;
                exp_stb = (pend_slot == 7);
            end
        end
        if (sw_wr_stb) stb_seen++;
        if (cmp_on) begin
            chk(vol_code == mreg[0][5:0] && zc_mode == mreg[0][7], "R4 R12 volume",
                {zc_mode, vol_code}, {mreg[0][7], mreg[0][5:0]});
            chk(att_r == mreg[1][5:0] && att_l == mreg[2][5:0], "R5 R12 attenuation",
                {att_l, att_r}, {mreg[2][5:0], mreg[1][5:0]});
            chk(bass_code == mreg[5][4:0] && treb_code == mreg[6][4:0], "R5 R12 tone",
                {treb_code, bass_code}, {mreg[6][4:0], mreg[5][4:0]});
            chk(gen_mute == mreg[7][7] && src_sel == mreg[7][2:0], "R6 R12 switch",
                {gen_mute, src_sel}, {mreg[7][7], mreg[7][2:0]});
            chk(sw_wr_stb == exp_stb, "R9 strobe", sw_wr_stb, exp_stb);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, input int nbits, input bit apply,
                             input int slot, output bit acked);
        acked = 1'b0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sda_m = b[i]; tick(HP);
            scl_m = 1'b1;
            if (i == 0 && apply) begin
                pend_slot = slot;
                pend_val  = b;
                pend_cnt  = 5;
            end
            tick(HP);
            scl_m = 1'b0; tick(HP);
        end
        if (nbits == 8) begin
            sda_m = 1'b1;
            scl_m = 1'b1; tick(HP / 2);
            acked = (sda_line == 1'b0);
            tick(HP / 2);
            scl_m = 1'b0; tick(HP);
        end
    endtask

    task automatic xfer(input logic [7:0] addr, input logic [7:0] sub, input bit do_stop);
        bit a;
        bit match;
        int ptr;
        match = (addr == DEV);
        i2c_start();
        send_byte(addr, 8, 1'b0, 0, a);
        chk(a == match, "R1 address acknowledge", a, match);
        send_byte(sub, 8, 1'b0, 0, a);
        chk(a == match, "R11 pointer acknowledge", a, match);
        ptr = int'(sub[2:0]);
        foreach (dq[k]) begin
            send_byte(dq[k], 8, match, ptr, a);
            chk(a == match, "R11 data acknowledge", a, match);
            ptr = (ptr + 1) % 8;
        end
        if (do_stop) i2c_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pend_cnt = 0;
        rst_pend = 2;
        tick(4);
        rst_n = 1'b1;
        tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        bit a;
        int s0;
        logic [40:0] snap;
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick(2);
        cmp_on = 1'b1;
        // R8 reset state
        chk(gen_mute == 1'b1 && vol_code == 0 && src_sel == 0 && bass_code == 0,
            "R8 reset fields", {gen_mute, src_sel}, 8);
        chk(sda_oe == 1'b0, "R8 reset releases SDA", sda_oe, 0);

        // Full map sweep from slot 0, with unused slots and don't-care bits
        s0 = stb_seen;
        dq = '{8'hC5, 8'h3A, 8'hFF, 8'hAA, 8'h55, 8'h13, 8'h1E, 8'h06};
        xfer(DEV, 8'h00, 1'b1);
        tick(HP);
        chk(vol_code == 6'd5 && zc_mode == 1'b1, "R4 volume decode", {zc_mode, vol_code}, 8'h45);
        chk(att_l == 6'h3F && att_r == 6'h3A, "R5 attenuation decode", {att_l, att_r}, 12'hFFA);
        chk(bass_code == 5'h13 && treb_code == 5'h1E, "R5 tone decode", {treb_code, bass_code}, 10'h3D3);
        chk(gen_mute == 1'b0 && src_sel == 3'b110, "R6 switch decode", {gen_mute, src_sel}, 4'h6);
        chk(stb_seen - s0 == 1, "R9 one strobe per switch write", stb_seen - s0, 1);

        // High pointer bits ignored, wrap from switch slot to volume slot
        s0 = stb_seen;
        dq = '{8'h07, 8'h87, 8'h3F};
        xfer(DEV, 8'hF6, 1'b1);
        tick(HP);
        chk(treb_code == 5'h07, "R2 pointer low bits select treble", treb_code, 7);
        chk(vol_code == 6'h3F && zc_mode == 1'b0, "R3 wrap to volume slot", {zc_mode, vol_code}, 8'h3F);
        chk(gen_mute == 1'b1 && src_sel == 3'b111, "R6 mute and stereo A", {gen_mute, src_sel}, 4'hF);
        chk(stb_seen - s0 == 1, "R9 strobe count after wrap", stb_seen - s0, 1);

        // Unused slots leave every output unchanged
        snap = {vol_code, zc_mode, att_r, att_l, bass_code, treb_code, gen_mute, src_sel, sw_wr_stb};
        dq = '{8'h00, 8'hFF};
        xfer(DEV, 8'h03, 1'b1);
        tick(HP);
        chk(snap == {vol_code, zc_mode, att_r, att_l, bass_code, treb_code, gen_mute, src_sel, sw_wr_stb},
            "R7 unused slots", 0, 0);

        // Wrong addresses: one bit off, and the read flag set
        dq = '{8'h00};
        xfer(8'h52, 8'h07, 1'b1);
        xfer(8'h51, 8'h07, 1'b1);
        tick(HP);
        chk(gen_mute == 1'b1, "R1 foreign address writes nothing", gen_mute, 1);

        // Repeated START closes one transfer and opens the next
        dq = '{8'h11};
        xfer(DEV, 8'h01, 1'b0);
        dq = '{8'h22};
        xfer(DEV, 8'h02, 1'b1);
        tick(HP);
        chk(att_r == 6'h11 && att_l == 6'h22, "R10 repeated start", {att_l, att_r}, 12'h891);

        // Partial byte ended by STOP, then by repeated START
        dq.delete();
        xfer(DEV, 8'h05, 1'b0);
        send_byte(8'hAB, 4, 1'b0, 0, a);
        i2c_stop();
        dq.delete();
        xfer(DEV, 8'h05, 1'b0);
        send_byte(8'hFF, 3, 1'b0, 0, a);
        dq = '{8'h09};
        xfer(DEV, 8'h06, 1'b1);
        tick(HP);
        chk(bass_code == 5'h13, "R10 partial bytes discarded", bass_code, 5'h13);
        chk(treb_code == 5'h09, "R10 byte after repeated start", treb_code, 9);

        // Reset in the middle of a transfer
        dq = '{8'h00};
        xfer(DEV, 8'h07, 1'b1);
        dq.delete();
        xfer(DEV, 8'h00, 1'b0);
        send_byte(8'hC0, 3, 1'b0, 0, a);
        do_reset();
        send_byte(DEV, 8, 1'b0, 0, a);
        chk(a == 1'b0, "R8 no acknowledge without START", a, 0);
        i2c_stop();
        tick(HP);
        chk(gen_mute == 1'b1 && treb_code == 0 && att_l == 0, "R8 mid-transfer reset",
            {gen_mute, treb_code}, 6'h20);

        tick(HP);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule